// File: doc/BRIEF.md
# Tile Transpose Buffer

This block holds one square tile of 8-bit samples, four rows of four samples with each row packed into one 32-bit word. It sits between the vertical-edge pass and the horizontal-edge pass of a block-edge smoothing filter. The vertical pass leaves its partly filtered samples here one row at a time. The horizontal pass then needs four vertically adjacent samples together.

A read can take a whole stored row or a whole column, so either orientation of the tile comes back in a single access. Without the buffer, gathering a column would take four word reads from a 32-bit wide memory.

Reads are registered. The word selected by the direction and index inputs appears on the output one clock after the read request and stays there until the next request. A write updates its entry at the clock edge. A read of that entry in the same cycle therefore returns the contents held before the write.

Top module: `tpose_buf`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every entry and `rd_data_o` read as zero until the first write.
- R2: When `wr_en_i` is 1 at a rising clock edge, the entry selected by `wr_row_i` takes the value of `wr_data_i`.
- R3: A read with `rd_col_i`=0 and `rd_idx_i`=k returns entry k unchanged on `rd_data_o`.
- R4: A read with `rd_col_i`=1 and `rd_idx_i`=k returns a column. Bits [8j+7:8j] of the result equal bits [8k+7:8k] of entry j, for j = 0..3, so entry 0 supplies the least significant byte.
- R5: `rd_data_o` changes one cycle after a clock edge at which `rd_en_i` is 1. While `rd_en_i` is 0 it holds its value, even when the entries change.
- R6: When a read and a write address the same entry in one cycle, the read returns the old contents. A read in a later cycle returns the new data.
- R7: While `wr_en_i` is 0, no entry changes, whatever the values on `wr_row_i` and `wr_data_i`.
- R8: A write changes only the entry it addresses. In a later column read, only the byte that comes from that entry differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_row_i | input | 2 | Entry (row) to write |
| wr_data_i | input | 32 | Row of four samples, sample 0 in bits [7:0] |
| rd_en_i | input | 1 | Read strobe |
| rd_col_i | input | 1 | 0 = row read, 1 = column read |
| rd_idx_i | input | 2 | Row number or column (lane) number to read |
| rd_data_o | output | 32 | Registered read result |

## Verification
Writes take effect at the edge that samples them. Read data appears on `rd_data_o` one edge after the strobe. The bench drives every input on the falling edge and compares the output on the next falling edge, which is the first point where the registered result is settled.

For the collision case, the read is checked at that same point against the tile as it was before the write. A later read is then checked against the updated tile. The hold case writes to the row just read and waits one full cycle with the strobe low before comparing again.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  typedef enum logic {
    RD_ROW = 1'b0,
    RD_COL = 1'b1
  } rd_dir_e;
endpackage

// File: rtl/tpose_store.sv
module tpose_store #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 8,
  localparam int ROW_W   = LANES * SAMPLE_W,
  localparam int IDX_W   = $clog2(LANES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_row_i,
  input  logic [ROW_W-1:0]            wr_data_i,
  output logic [LANES-1:0][ROW_W-1:0] rows_o
);
  logic [LANES-1:0][ROW_W-1:0] rows_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rows_q <= '0;
    else if (wr_en_i) rows_q[wr_row_i] <= wr_data_i;
  end

  assign rows_o = rows_q;

  p_wr_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rows_q[$past(wr_row_i)] == $past(wr_data_i));

  for (genvar g = 0; g < LANES; g++) begin : g_keep
    p_row_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i || (wr_row_i != IDX_W'(g))) |=> $stable(rows_q[g]));
  end
endmodule

// File: rtl/tpose_mux.sv
module tpose_mux
  import tpose_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 8,
  localparam int ROW_W   = LANES * SAMPLE_W,
  localparam int IDX_W   = $clog2(LANES)
) (
  input  logic [LANES-1:0][ROW_W-1:0] rows_i,
  input  rd_dir_e                     dir_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [ROW_W-1:0]            data_o
);
  logic [ROW_W-1:0] col_word;

  // lane idx_i of each row, row j lands in lane j
  for (genvar j = 0; j < LANES; j++) begin : g_col
    assign col_word[j*SAMPLE_W +: SAMPLE_W] = rows_i[j][int'(idx_i)*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    if (dir_i == RD_COL) data_o = col_word;
    else                 data_o = rows_i[idx_i];
  end
endmodule

// File: rtl/tpose_buf.sv
module tpose_buf
  import tpose_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 8,
  localparam int ROW_W   = LANES * SAMPLE_W,
  localparam int IDX_W   = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_row_i,
  input  logic [ROW_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             rd_col_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ROW_W-1:0] rd_data_o
);
  logic [LANES-1:0][ROW_W-1:0] rows_w;
  logic [ROW_W-1:0]            sel_w;
  logic [ROW_W-1:0]            rd_q;
  rd_dir_e                     dir_w;

  assign dir_w = rd_col_i ? RD_COL : RD_ROW;

  tpose_store #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_row_i  (wr_row_i),
    .wr_data_i (wr_data_i),
    .rows_o    (rows_w)
  );

  tpose_mux #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_mux (
    .rows_i (rows_w),
    .dir_i  (dir_w),
    .idx_i  (rd_idx_i),
    .data_o (sel_w)
  );

  // sampled before any same-edge write lands: old data on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= sel_w;
  end

  assign rd_data_o = rd_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  p_row_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_col_i) |=> rd_data_o == $past(rows_w[rd_idx_i]));

  p_collide_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_col_i && wr_en_i && wr_row_i == rd_idx_i)
      |=> rd_data_o == $past(rows_w[rd_idx_i]));

  for (genvar j = 0; j < LANES; j++) begin : g_col_chk
    p_col_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && rd_col_i) |=> rd_data_o[j*SAMPLE_W +: SAMPLE_W]
        == $past(rows_w[j][int'(rd_idx_i)*SAMPLE_W +: SAMPLE_W]));
  end
endmodule

// File: tb/tpose_buf_tb.sv
module tpose_buf_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_row_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic        rd_col_i = 1'b0;
  logic [1:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] model [4];

  tpose_buf u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic report();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      report();
    end
  end

  function automatic logic [31:0] expect_word(bit col, int idx);
    logic [31:0] w;
    if (!col) return model[idx];
    for (int j = 0; j < 4; j++) w[j*8 +: 8] = model[j][idx*8 +: 8];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int row, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_row_i = 2'(row); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[row] = d;
  endtask

  // strobe at negedge, result due at next negedge
  task automatic rd(string req, bit col, int idx);
    logic [31:0] e;
    e = expect_word(col, idx);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_col_i = col; rd_idx_i = 2'(idx);
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(req, rd_data_o, e);
  endtask

  initial begin
    logic [31:0] held, old_w, d;
    for (int r = 0; r < 4; r++) model[r] = '0;
    repeat (3) @(negedge clk_i);
    check("R1 during reset", rd_data_o, 32'h0);
    rst_ni = 1'b1;
    check("R1 after release", rd_data_o, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd("R1 row", 1'b0, k);
      rd("R1 col", 1'b1, k);
    end

    // R2 R3 R4: full tile patterns, sweep every row and column
    for (int p = 0; p < 5; p++) begin
      for (int r = 0; r < 4; r++) begin
        for (int l = 0; l < 4; l++) d[l*8 +: 8] = 8'((p*37 + r*11 + l*5 + 1) ^ (p*64));
        wr(r, d);
      end
      for (int k = 0; k < 4; k++) rd("R2/R3 row", 1'b0, k);
      for (int k = 0; k < 4; k++) rd("R4 col", 1'b1, k);
    end

    // R7: strobe low, other write inputs wiggle
    for (int r = 0; r < 4; r++) begin
      @(negedge clk_i);
      wr_row_i = 2'(r); wr_data_i = 32'hdead_0000 | 32'(r);
    end
    for (int k = 0; k < 4; k++) rd("R7 row", 1'b0, k);

    // R8: one row rewritten, columns differ only in that byte
    wr(2, 32'hA1B2C3D4);
    for (int k = 0; k < 4; k++) rd("R8 col", 1'b1, k);
    rd("R8 row", 1'b0, 1);

    // R5: hold with read strobe low while the read row changes
    rd("R5 read", 1'b0, 3);
    held = rd_data_o;
    wr(3, 32'h0F1E2D3C);
    @(negedge clk_i);
    check("R5 hold", rd_data_o, held);
    rd("R5 next read", 1'b0, 3);

    // R6: collision, row then column
    for (int c = 0; c < 2; c++) begin
      old_w = expect_word(c[0], 1);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_row_i = 2'd1; wr_data_i = 32'h55AA_1200 + 32'(c);
      rd_en_i = 1'b1; rd_col_i = c[0]; rd_idx_i = 2'd1;
      @(negedge clk_i);
      wr_en_i = 1'b0; rd_en_i = 1'b0;
      model[1] = 32'h55AA_1200 + 32'(c);
      check("R6 old data", rd_data_o, old_w);
      rd("R6 new data", c[0], 1);
    end

    report();
  end
endmodule